// File: doc/BRIEF.md
# Watchdog-Triggered Reset Sequencer

This block orders the recovery of a small controller after its watchdog expires or after power-on. A single-cycle overflow strobe starts the sequence. The block asserts the internal reset, which also clears the watchdog. It stops the oscillator, gates the CPU clock, floats the general port pins and drives a dedicated reset-indication pin low. It then steps through four phases: reset-active, an option-configuration fetch wait, an optional oscillation-stabilization count, and normal operation.

The stabilization count runs only when the clock source is a crystal or ceramic resonator. It lasts 2^(10+code) cycles, where the code is 0 to 7. Internal-oscillator and external-clock sources go straight to normal operation after the option wait. A power-on reset runs the same sequence with the largest exponent, 17. All control outputs come from flops, so they are free of glitches. The current phase is reported on a 3-bit status output.

Top module: `wdt_reset_sequencer`

## Requirements
- R1: While `rst_n` is low, the outputs are: `phase` = 1 (reset-active), `int_rst` = 1, `osc_en` = 0, `cpu_clk_en` = 0, `port_drv_en` = all zeros and `rst_pin` = 0.
- R2: The reset-active phase (`phase` = 1) lasts exactly RST_CYC cycles (default 16). Throughout it, `int_rst` = 1, `osc_en` = 0 and `cpu_clk_en` = 0.
- R3: The option-fetch wait (`phase` = 2) follows the reset-active phase and lasts `opt_cycles` cycles, or 1 cycle when `opt_cycles` is 0. During it, `int_rst` = 0, `osc_en` = 1 and `cpu_clk_en` = 0.
- R4: When the sequence uses a crystal source (`xtal_sel` = 1), a stabilization phase (`phase` = 3) follows the option wait. It lasts 2^(10+`stab_exp`) cycles, with `osc_en` = 1, `int_rst` = 0 and `cpu_clk_en` = 0.
- R5: When `xtal_sel` = 0, the option wait is followed directly by normal operation (`phase` = 0), with no stabilization phase.
- R6: In normal operation (`phase` = 0), the outputs are `cpu_clk_en` = 1, `osc_en` = 1, `int_rst` = 0 and `port_drv_en` = all ones.
- R7: A `wdt_ovf` pulse sampled in normal operation gives, from the next cycle: `phase` = 1, `int_rst` = 1, `cpu_clk_en` = 0, `osc_en` = 0, `port_drv_en` = 0 and `rst_pin` = 0.
- R8: A `wdt_ovf` pulse sampled in any non-normal phase restarts the sequence. The reset-active phase then runs its full RST_CYC cycles from the next cycle.
- R9: The sequence started by power-on reset uses exponent 17 (2^17 stabilization cycles when the crystal source is chosen), whatever the value of `stab_exp`.
- R10: `rst_pin` is 0 in every non-normal phase and stays 0 after release until software writes it. In normal operation, `sw_pin_we` = 1 loads `sw_pin_val` into `rst_pin` in the next cycle. Writes made outside normal operation are ignored.
- R11: `xtal_sel` and `stab_exp` are sampled when the reset-active phase ends. Changes to them later in the same sequence have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| wdt_ovf | input | 1 | One-cycle watchdog overflow strobe |
| xtal_sel | input | 1 | 1 = crystal/ceramic clock source |
| stab_exp | input | 3 | Stabilization exponent code; the wait is 2^(10+code) cycles |
| opt_cycles | input | 16 | Length of the option-fetch wait in cycles (0 means 1) |
| sw_pin_we | input | 1 | Software write strobe for the indication pin |
| sw_pin_val | input | 1 | Level written to the indication pin |
| int_rst | output | 1 | Internal reset, which also clears the watchdog |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| port_drv_en | output | 8 | Output-drive enables for the general ports (0 = high impedance) |
| rst_pin | output | 1 | Level on the dedicated reset-indication pin |
| phase | output | 3 | Current phase: 0 normal, 1 reset, 2 option wait, 3 stabilization |

## Verification
The bench measures the length of each phase in a power-on sequence with a crystal source and a deliberately wrong exponent code. This separates the forced exponent 17 from the input code. Watchdog restarts follow with an internal-oscillator source, a crystal source with code 0, and an option length of zero; these separate the skipped stabilization phase from a real one and check the minimum option wait. Overflow pulses are injected during the option wait and during the stabilization count, and each must restart a full-length reset phase. Pin writes are made both inside and outside normal operation. A configuration change after the reset phase must leave the stabilization length unchanged.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  typedef enum logic [2:0] {
    PH_NORMAL = 3'd0,
    PH_RESET  = 3'd1,
    PH_OPTREF = 3'd2,
    PH_STAB   = 3'd3
  } phase_t;

  // stabilization length: 2^(base + code)
  function automatic int unsigned stab_cycles(int unsigned base, int unsigned code);
    return 32'd1 << (base + code);
  endfunction

  // option-fetch wait length: a programmed zero means one cycle
  function automatic int unsigned optref_cycles(int unsigned prog);
    return (prog == 0) ? 32'd1 : prog;
  endfunction
endpackage

// File: rtl/wrs_timer.sv
module wrs_timer #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  assign done = (cnt == limit - 1'b1);
endmodule

// File: rtl/wrs_ctrl.sv
module wrs_ctrl
  import wrs_pkg::*;
#(
  parameter int RST_CYC  = 16,
  parameter int OPT_W    = 16,
  parameter int EXP_BASE = 10,
  parameter int EXP_W    = 3,
  parameter int CNT_W    = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdt_ovf,
  input  logic             xtal_sel,
  input  logic [EXP_W-1:0] stab_exp,
  input  logic [OPT_W-1:0] opt_cycles,
  input  logic             tmr_done,
  output logic             tmr_clr,
  output logic [CNT_W-1:0] tmr_limit,
  output logic             nxt_normal,
  output logic             cur_normal,
  output logic             int_rst,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic [2:0]       phase
);
  phase_t           ph_q, ph_d;
  logic             por_flag;
  logic             cfg_xtal;
  logic [EXP_W-1:0] cfg_exp;
  logic             leave_reset;

  always_comb begin
    ph_d = ph_q;
    if (wdt_ovf) ph_d = PH_RESET;
    else if (ph_q != PH_NORMAL && tmr_done) begin
      unique case (ph_q)
        PH_RESET:  ph_d = PH_OPTREF;
        PH_OPTREF: ph_d = cfg_xtal ? PH_STAB : PH_NORMAL;
        default:   ph_d = PH_NORMAL;
      endcase
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_RESET:  tmr_limit = CNT_W'(RST_CYC);
      PH_OPTREF: tmr_limit = CNT_W'(optref_cycles(32'(opt_cycles)));
      PH_STAB:   tmr_limit = CNT_W'(stab_cycles(EXP_BASE, 32'(cfg_exp)));
      default:   tmr_limit = '0;
    endcase
  end

  assign tmr_clr     = (ph_d != ph_q) || wdt_ovf;
  assign leave_reset = (ph_q == PH_RESET) && (ph_d == PH_OPTREF);
  assign nxt_normal  = (ph_d == PH_NORMAL);
  assign cur_normal  = (ph_q == PH_NORMAL);
  assign phase       = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_RESET;
      por_flag   <= 1'b1;
      cfg_xtal   <= 1'b0;
      cfg_exp    <= '0;
      int_rst    <= 1'b1;
      osc_en     <= 1'b0;
      cpu_clk_en <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      int_rst    <= (ph_d == PH_RESET);
      osc_en     <= (ph_d != PH_RESET);
      cpu_clk_en <= (ph_d == PH_NORMAL);
      if (ph_d == PH_NORMAL) por_flag <= 1'b0;
      if (leave_reset) begin
        cfg_xtal <= xtal_sel;
        cfg_exp  <= por_flag ? {EXP_W{1'b1}} : stab_exp;
      end
    end
  end

  assert_rst_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |-> (!osc_en && !cpu_clk_en));
  assert_ovf_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_ovf |=> (int_rst && phase == 3'd1 && !cpu_clk_en));
  assert_stab_xtal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3) |-> cfg_xtal);
  assert_skip_stab_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2 && !cfg_xtal && !wdt_ovf) |=> (phase == 3'd2 || phase == 3'd0));
  assert_normal_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> (osc_en && !int_rst && $past(phase) != 3'd1));
endmodule

// File: rtl/wrs_pins.sv
module wrs_pins #(
  parameter int NPORT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nxt_normal,
  input  logic             cur_normal,
  input  logic             sw_pin_we,
  input  logic             sw_pin_val,
  output logic [NPORT-1:0] port_drv_en,
  output logic             rst_pin
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_drv_en <= '0;
      rst_pin     <= 1'b0;
    end else begin
      port_drv_en <= {NPORT{nxt_normal}};
      if (!nxt_normal)                  rst_pin <= 1'b0;
      else if (cur_normal && sw_pin_we) rst_pin <= sw_pin_val;
    end
  end

  assert_pin_release_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_drv_en[0]) |-> !rst_pin);
endmodule

// File: rtl/wdt_reset_sequencer.sv
module wdt_reset_sequencer
  import wrs_pkg::*;
#(
  parameter int RST_CYC  = 16,
  parameter int OPT_W    = 16,
  parameter int EXP_BASE = 10,
  parameter int EXP_W    = 3,
  parameter int NPORT    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdt_ovf,
  input  logic             xtal_sel,
  input  logic [EXP_W-1:0] stab_exp,
  input  logic [OPT_W-1:0] opt_cycles,
  input  logic             sw_pin_we,
  input  logic             sw_pin_val,
  output logic             int_rst,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic [NPORT-1:0] port_drv_en,
  output logic             rst_pin,
  output logic [2:0]       phase
);
  localparam int STAB_W = EXP_BASE + (1 << EXP_W);
  localparam int CNT_W  = (STAB_W > OPT_W) ? STAB_W : OPT_W;

  logic             tmr_clr, tmr_done, nxt_normal, cur_normal;
  logic [CNT_W-1:0] tmr_limit;

  wrs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(tmr_limit), .done(tmr_done)
  );

  wrs_ctrl #(
    .RST_CYC(RST_CYC), .OPT_W(OPT_W), .EXP_BASE(EXP_BASE),
    .EXP_W(EXP_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wdt_ovf(wdt_ovf), .xtal_sel(xtal_sel),
    .stab_exp(stab_exp), .opt_cycles(opt_cycles), .tmr_done(tmr_done),
    .tmr_clr(tmr_clr), .tmr_limit(tmr_limit), .nxt_normal(nxt_normal),
    .cur_normal(cur_normal), .int_rst(int_rst), .osc_en(osc_en),
    .cpu_clk_en(cpu_clk_en), .phase(phase)
  );

  wrs_pins #(.NPORT(NPORT)) u_pins (
    .clk(clk), .rst_n(rst_n), .nxt_normal(nxt_normal), .cur_normal(cur_normal),
    .sw_pin_we(sw_pin_we), .sw_pin_val(sw_pin_val),
    .port_drv_en(port_drv_en), .rst_pin(rst_pin)
  );
endmodule

// File: tb/test_wdt_reset_sequencer.sv
module test_wdt_reset_sequencer;
  localparam int RST_CYC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wdt_ovf = 1'b0, xtal_sel = 1'b0, sw_pin_we = 1'b0, sw_pin_val = 1'b0;
  logic [2:0]  stab_exp = 3'd0;
  logic [15:0] opt_cycles = 16'd20;
  logic        int_rst, osc_en, cpu_clk_en, rst_pin;
  logic [7:0]  port_drv_en;
  logic [2:0]  phase;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  wdt_reset_sequencer i_wdt_reset_sequencer (
    .clk(clk), .rst_n(rst_n), .wdt_ovf(wdt_ovf), .xtal_sel(xtal_sel),
    .stab_exp(stab_exp), .opt_cycles(opt_cycles), .sw_pin_we(sw_pin_we),
    .sw_pin_val(sw_pin_val), .int_rst(int_rst), .osc_en(osc_en),
    .cpu_clk_en(cpu_clk_en), .port_drv_en(port_drv_en), .rst_pin(rst_pin),
    .phase(phase)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int stab_len(int code);
    int v = 1024;
    for (int k = 0; k < code; k++) v = v * 2;
    return v;
  endfunction

  // count consecutive negedge samples spent in phase ph
  task automatic measure(input int ph, output int n);
    n = 0;
    while (phase == 3'(ph) && n < 150000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_ovf;
    wdt_ovf = 1'b1;
    @(negedge clk);
    wdt_ovf = 1'b0;
  endtask

  task automatic check_normal(string req);
    check({req, " phase"}, phase, 0);
    check({req, " cpu_clk_en"}, cpu_clk_en, 1);
    check({req, " osc_en"}, osc_en, 1);
    check({req, " int_rst"}, int_rst, 0);
    check({req, " port_drv_en"}, port_drv_en, 8'hFF);
  endtask

  task automatic t_por;
    int n;
    rst_n = 1'b0; xtal_sel = 1'b1; stab_exp = 3'd0; opt_cycles = 16'd20;
    repeat (3) @(negedge clk);
    check("R1 phase", phase, 1);
    check("R1 int_rst", int_rst, 1);
    check("R1 osc_en", osc_en, 0);
    check("R1 cpu_clk_en", cpu_clk_en, 0);
    check("R1 port_drv_en", port_drv_en, 0);
    check("R1 rst_pin", rst_pin, 0);
    rst_n = 1'b1;
    measure(1, n); check("R2 reset length", n, RST_CYC);
    check("R3 opt int_rst", int_rst, 0);
    check("R3 opt osc_en", osc_en, 1);
    check("R3 opt cpu off", cpu_clk_en, 0);
    measure(2, n); check("R3 opt length", n, 20);
    check("R4 stab cpu off", cpu_clk_en, 0);
    check("R4 stab osc on", osc_en, 1);
    measure(3, n); check("R9 por stab length", n, stab_len(7));
    check_normal("R6");
    check("R10 pin low after release", rst_pin, 0);
  endtask

  task automatic t_pin_and_ovf;
    sw_pin_we = 1'b1; sw_pin_val = 1'b1;
    @(negedge clk);
    sw_pin_we = 1'b0;
    check("R10 sw write high", rst_pin, 1);
    pulse_ovf();
    check("R7 phase", phase, 1);
    check("R7 int_rst", int_rst, 1);
    check("R7 cpu off", cpu_clk_en, 0);
    check("R7 osc off", osc_en, 0);
    check("R7 ports float", port_drv_en, 0);
    check("R7 pin low", rst_pin, 0);
  endtask

  task automatic t_internal_osc;
    int n;
    xtal_sel = 1'b0; opt_cycles = 16'd5;
    measure(1, n); check("R2 reset length after ovf", n, RST_CYC);
    measure(2, n); check("R3 opt length 5", n, 5);
    check("R5 no stab phase", phase, 0);
    check_normal("R5");
  endtask

  task automatic t_xtal_short;
    int n;
    xtal_sel = 1'b1; stab_exp = 3'd0; opt_cycles = 16'd0;
    pulse_ovf();
    measure(1, n); check("R2 reset length xtal", n, RST_CYC);
    measure(2, n); check("R3 opt zero means one", n, 1);
    measure(3, n); check("R4 stab length code0", n, stab_len(0));
    check_normal("R4");
  endtask

  task automatic t_restart;
    int n;
    opt_cycles = 16'd30;
    pulse_ovf();
    measure(1, n);
    repeat (10) @(negedge clk);
    check("R8 in opt", phase, 2);
    // software write outside normal must be ignored
    sw_pin_we = 1'b1; sw_pin_val = 1'b1;
    pulse_ovf();
    sw_pin_we = 1'b0;
    check("R10 write ignored in reset", rst_pin, 0);
    measure(1, n); check("R8 restart from opt", n, RST_CYC);
    measure(2, n);
    repeat (100) @(negedge clk);
    check("R8 in stab", phase, 3);
    pulse_ovf();
    measure(1, n); check("R8 restart from stab", n, RST_CYC);
    measure(2, n); measure(3, n);
    check("R10 pin still low at normal", rst_pin, 0);
  endtask

  task automatic t_cfg_sample;
    int n;
    xtal_sel = 1'b1; stab_exp = 3'd1; opt_cycles = 16'd4;
    pulse_ovf();
    measure(1, n);
    xtal_sel = 1'b0; stab_exp = 3'd3;
    measure(2, n);
    check("R11 stab phase kept", phase, 3);
    measure(3, n); check("R11 stab length from sampled code", n, stab_len(1));
    check_normal("R11");
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_por();
    t_pin_and_ovf();
    t_internal_osc();
    t_xtal_short();
    t_restart();
    t_cfg_sample();
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule